// File: doc/BRIEF.md
# Serial EEPROM Bus Target

This block is a two-wire bus target that behaves like a small byte-wide serial EEPROM. By default it holds 256 bytes, and a parameter selects a 128-byte array. SCL and SDA first pass through glitch filters. The block then finds START and STOP conditions and decodes each transaction. A transaction is a device-select byte, then a one-byte word address, then data bytes that are either written to the target or read from it. The target drives SDA only low, through an output-enable pin. The board or the bench provides the pull-up.

Write data collects in an 8-byte page buffer. A STOP that follows whole data bytes starts a self-timed write cycle, and the array is updated when that cycle ends. While the cycle runs, the target does not answer its device-select byte, so a master polls it to learn when the write is done. A write-protect input keeps the array unchanged. Reads begin at any address set by a dummy write, and they continue through consecutive addresses for as long as the master acknowledges.

Top module: `eeprom_i2c_target`

## Requirements
- R1: After reset, sdaOe is low, no write cycle runs, and every array byte reads as 0xFF.
- R2: Bits 7:4 of a device-select byte must be 1010 and bits 3:1 must equal pinAddr. Bit 0 is the direction, with 1 meaning read. The target acknowledges only a matching byte. After any other byte it drives nothing until the next START.
- R3: A write transaction is a device-select byte with bit 0 = 0, a word address, one data byte and a STOP. After the write cycle, the addressed byte holds the data and the neighbouring bytes are unchanged.
- R4: During a page write, the low 3 bits of the address count up after each data byte and wrap inside the 8-byte page. Bytes past the eighth overwrite earlier bytes of the same page.
- R5: The write cycle lasts WRITE_CYCLES clocks after the STOP. During that time the target does not acknowledge its device-select byte. Afterwards it does.
- R6: If wpIn is high at the STOP, the data bytes are still acknowledged, but the array is unchanged and no write cycle starts.
- R7: A random read is a dummy write of the word address, then a repeated START and a read device-select byte. It returns the byte at that address, MSB first.
- R8: In a sequential read, each master ACK makes the next byte come from the address plus one. The address wraps from the last location to 0. After a master NACK the target releases SDA.
- R9: A START or STOP that arrives after 2 to 7 bits of a byte discards every data byte of that transaction. No write cycle starts.
- R10: A pulse on SCL or SDA shorter than FILTER_CYCLES clocks has no effect on decoding.
- R11: With MEM_BYTES = 128, the MSB of the word address is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Sampled serial clock line |
| sdaIn | input | 1 | Sampled serial data line |
| wpIn | input | 1 | Write protect, high blocks array updates |
| pinAddr | input | 3 | Strap value compared with device-select bits 3:1 |
| sdaOe | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
The target reacts to each filtered SCL edge a fixed number of clocks after the edge on the wire: two synchroniser stages, FILTER_CYCLES filter clocks, then one register. With the defaults this is about seven clocks. The bench therefore holds every SCL phase for ten clocks. It changes SDA only in the middle of SCL-low and samples the acknowledge and read bits in the middle of SCL-high, where the target's output has already settled. Array contents are checked only after polling shows that the write cycle has finished. Released-bus checks are made a quarter bit after the STOP.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;

  typedef struct packed {
    logic       loadAddr;
    logic       pushData;
    logic       incAddr;
    logic       startWrite;
    logic       dropPage;
    logic [7:0] byteVal;
  } dpCmd_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEVSEL,
    ST_ACKDEV,
    ST_ADDR,
    ST_ACKADDR,
    ST_WDATA,
    ST_ACKWDATA,
    ST_RDATA,
    ST_RACK
  } busState_t;

endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
  parameter int STABLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int CNT_W = $clog2(STABLE_CYCLES + 1);

  logic [1:0]       syncQ;
  logic [CNT_W-1:0] runQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ    <= 2'b11;
      cleanOut <= 1'b1;
      runQ     <= '0;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (syncQ[1] == cleanOut) begin
        runQ <= '0;
      end else if (runQ == CNT_W'(STABLE_CYCLES - 1)) begin
        cleanOut <= syncQ[1];
        runQ     <= '0;
      end else begin
        runQ <= runQ + CNT_W'(1);
      end
    end
  end

  // the output only follows a level that was present for more than one sample
  p_filter_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cleanOut != $past(cleanOut)) |-> ($past(syncQ[1], 1) == cleanOut && $past(syncQ[1], 2) == cleanOut));

endmodule

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_i2c_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclF,
  input  logic       sdaF,
  input  logic       wpIn,
  input  logic [2:0] pinAddr,
  input  logic       busy,
  input  logic [7:0] rdByte,
  output logic       sdaOe,
  output dpCmd_t     cmd
);
  busState_t  stateQ;
  logic [3:0] bitCntQ;
  logic [7:0] shiftQ;
  logic       sclQ, sdaQ;
  logic       rwQ, dataSeenQ, ackBitQ;

  logic sclRise, sclFall, startCond, stopCond, byteEdge;
  assign sclRise   = sclF & ~sclQ;
  assign sclFall   = ~sclF & sclQ;
  assign startCond = sclF & sclQ & sdaQ & ~sdaF;
  assign stopCond  = sclF & sclQ & ~sdaQ & sdaF;
  // a condition seen with at most the first clock of a byte counted lies on a byte boundary
  assign byteEdge  = (bitCntQ <= 4'd1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      bitCntQ   <= '0;
      shiftQ    <= '0;
      sclQ      <= 1'b1;
      sdaQ      <= 1'b1;
      rwQ       <= 1'b0;
      dataSeenQ <= 1'b0;
      ackBitQ   <= 1'b0;
      sdaOe     <= 1'b0;
      cmd       <= '0;
    end else begin
      sclQ <= sclF;
      sdaQ <= sdaF;
      cmd  <= '0;
      if (startCond) begin
        stateQ       <= ST_DEVSEL;
        bitCntQ      <= '0;
        sdaOe        <= 1'b0;
        dataSeenQ    <= 1'b0;
        cmd.dropPage <= 1'b1;
      end else if (stopCond) begin
        stateQ    <= ST_IDLE;
        sdaOe     <= 1'b0;
        dataSeenQ <= 1'b0;
        if (stateQ == ST_WDATA && byteEdge && dataSeenQ && !wpIn) cmd.startWrite <= 1'b1;
        else cmd.dropPage <= 1'b1;
      end else if (sclRise) begin
        case (stateQ)
          ST_DEVSEL, ST_ADDR, ST_WDATA: begin
            shiftQ  <= {shiftQ[6:0], sdaF};
            bitCntQ <= bitCntQ + 4'd1;
          end
          ST_RDATA: bitCntQ <= bitCntQ + 4'd1;
          ST_RACK:  ackBitQ <= ~sdaF;
          default: ;
        endcase
      end else if (sclFall) begin
        case (stateQ)
          ST_DEVSEL: if (bitCntQ == 4'd8) begin
            if (shiftQ[7:1] == {4'b1010, pinAddr} && !busy) begin
              sdaOe  <= 1'b1;
              rwQ    <= shiftQ[0];
              stateQ <= ST_ACKDEV;
            end else begin
              stateQ <= ST_IDLE;
            end
          end
          ST_ADDR: if (bitCntQ == 4'd8) begin
            sdaOe        <= 1'b1;
            cmd.loadAddr <= 1'b1;
            cmd.byteVal  <= shiftQ;
            stateQ       <= ST_ACKADDR;
          end
          ST_WDATA: if (bitCntQ == 4'd8) begin
            sdaOe        <= 1'b1;
            cmd.pushData <= 1'b1;
            cmd.byteVal  <= shiftQ;
            dataSeenQ    <= 1'b1;
            stateQ       <= ST_ACKWDATA;
          end
          ST_ACKDEV: begin
            bitCntQ <= '0;
            if (rwQ) begin
              stateQ <= ST_RDATA;
              sdaOe  <= ~rdByte[7];
            end else begin
              stateQ <= ST_ADDR;
              sdaOe  <= 1'b0;
            end
          end
          ST_ACKADDR, ST_ACKWDATA: begin
            bitCntQ <= '0;
            sdaOe   <= 1'b0;
            stateQ  <= ST_WDATA;
          end
          ST_RDATA: begin
            if (bitCntQ == 4'd8) begin
              sdaOe       <= 1'b0;
              cmd.incAddr <= 1'b1;
              stateQ      <= ST_RACK;
            end else begin
              sdaOe <= ~rdByte[3'(4'd7 - bitCntQ)];
            end
          end
          ST_RACK: begin
            if (ackBitQ) begin
              stateQ  <= ST_RDATA;
              bitCntQ <= '0;
              sdaOe   <= ~rdByte[7];
            end else begin
              stateQ <= ST_IDLE;
              sdaOe  <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_no_ack_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ACKDEV) |-> !busy);

  p_oe_states_r2: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe |-> (stateQ inside {ST_ACKDEV, ST_ACKADDR, ST_ACKWDATA, ST_RDATA}));

  p_wp_block_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmd.startWrite |-> !$past(wpIn));

  p_commit_after_data_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmd.startWrite |-> ($past(stateQ) == ST_WDATA && $past(bitCntQ) <= 4'd1));

endmodule

// File: rtl/eeprom_datapath.sv
module eeprom_datapath
  import eeprom_i2c_pkg::*;
#(
  parameter int MEM_BYTES    = 256,
  parameter int PAGE_BYTES   = 8,
  parameter int WRITE_CYCLES = 250000
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCmd_t     cmd,
  output logic       busy,
  output logic [7:0] rdByte
);
  localparam int ADDR_W  = $clog2(MEM_BYTES);
  localparam int OFF_W   = $clog2(PAGE_BYTES);
  localparam int TIMER_W = $clog2(WRITE_CYCLES + 1);

  logic [7:0]            memQ     [MEM_BYTES];
  logic [7:0]            pageBufQ [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] validQ;
  logic [ADDR_W-1:0]     addrQ;
  logic [TIMER_W-1:0]    timerQ;
  logic                  busyQ;

  assign busy   = busyQ;
  assign rdByte = memQ[addrQ];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) memQ[i] <= 8'hFF;
      for (int i = 0; i < PAGE_BYTES; i++) pageBufQ[i] <= 8'h00;
      validQ <= '0;
      addrQ  <= '0;
      timerQ <= '0;
      busyQ  <= 1'b0;
    end else begin
      if (cmd.loadAddr) begin
        addrQ <= cmd.byteVal[ADDR_W-1:0];
      end else if (cmd.pushData) begin
        pageBufQ[addrQ[OFF_W-1:0]] <= cmd.byteVal;
        validQ[addrQ[OFF_W-1:0]]   <= 1'b1;
        addrQ <= {addrQ[ADDR_W-1:OFF_W], addrQ[OFF_W-1:0] + OFF_W'(1)};
      end else if (cmd.incAddr) begin
        addrQ <= addrQ + ADDR_W'(1);
      end

      if (busyQ) begin
        if (timerQ == '0) begin
          for (int i = 0; i < PAGE_BYTES; i++)
            if (validQ[i]) memQ[{addrQ[ADDR_W-1:OFF_W], OFF_W'(i)}] <= pageBufQ[i];
          validQ <= '0;
          busyQ  <= 1'b0;
        end else begin
          timerQ <= timerQ - TIMER_W'(1);
        end
      end else if (cmd.startWrite && |validQ) begin
        busyQ  <= 1'b1;
        timerQ <= TIMER_W'(WRITE_CYCLES - 1);
      end else if (cmd.dropPage) begin
        validQ <= '0;
      end
    end
  end

  p_no_push_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.pushData |-> !busyQ);

  p_page_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && $past(busyQ)) |-> ($stable(validQ) && $stable(addrQ)));

  p_page_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmd.pushData) |-> (addrQ[ADDR_W-1:OFF_W] == $past(addrQ[ADDR_W-1:OFF_W])));

  p_seq_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmd.incAddr) |-> (addrQ == ADDR_W'($past(addrQ) + ADDR_W'(1))));

endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
  import eeprom_i2c_pkg::*;
#(
  parameter int MEM_BYTES     = 256,
  parameter int PAGE_BYTES    = 8,
  parameter int FILTER_CYCLES = 4,
  parameter int WRITE_CYCLES  = 250000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       wpIn,
  input  logic [2:0] pinAddr,
  output logic       sdaOe
);
  logic [1:0] rawLines, cleanLines;
  dpCmd_t     cmd;
  logic       busy;
  logic [7:0] rdByte;

  assign rawLines = {sdaIn, sclIn};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2c_glitch_filter #(.STABLE_CYCLES(FILTER_CYCLES)) u_filt (
      .clk      (clk),
      .rstN     (rstN),
      .rawIn    (rawLines[g]),
      .cleanOut (cleanLines[g])
    );
  end

  eeprom_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclF    (cleanLines[0]),
    .sdaF    (cleanLines[1]),
    .wpIn    (wpIn),
    .pinAddr (pinAddr),
    .busy    (busy),
    .rdByte  (rdByte),
    .sdaOe   (sdaOe),
    .cmd     (cmd)
  );

  eeprom_datapath #(
    .MEM_BYTES    (MEM_BYTES),
    .PAGE_BYTES   (PAGE_BYTES),
    .WRITE_CYCLES (WRITE_CYCLES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .busy   (busy),
    .rdByte (rdByte)
  );

endmodule

// File: tb/eeprom_i2c_target_bench.sv
module eeprom_i2c_target_bench;
  localparam int Q  = 10;
  localparam int WR = 1000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0, sclM = 1'b1, sdaMOe = 1'b0, wp = 1'b0;
  logic oeBig, oeSmall, sdaBus;
  assign sdaBus = ~(sdaMOe | oeBig | oeSmall);

  int total = 0, bad = 0;
  logic [7:0] rdBuf [8];

  eeprom_i2c_target #(.MEM_BYTES(256), .WRITE_CYCLES(WR)) u_eeprom_i2c_target (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .wpIn(wp),
    .pinAddr(3'b000), .sdaOe(oeBig));

  eeprom_i2c_target #(.MEM_BYTES(128), .WRITE_CYCLES(WR)) u_small (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .wpIn(wp),
    .pinAddr(3'b101), .sdaOe(oeSmall));

  task automatic checkEq(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic startC();
    sdaMOe = 1'b0; waitq(); sclM = 1'b1; waitq(); sdaMOe = 1'b1; waitq(); sclM = 1'b0; waitq();
  endtask

  task automatic stopC();
    sdaMOe = 1'b1; waitq(); sclM = 1'b1; waitq(); sdaMOe = 1'b0; waitq();
  endtask

  task automatic sendBit(input bit b, input bit glitch);
    sdaMOe = ~b;
    if (glitch) begin
      repeat (3) @(negedge clk); sclM = 1'b1;
      repeat (2) @(negedge clk); sclM = 1'b0;
      repeat (Q - 5) @(negedge clk);
    end else waitq();
    sclM = 1'b1; waitq(); waitq(); sclM = 1'b0; waitq();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) sendBit(b[7-i], 1'b0);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i], glitch);
    sdaMOe = 1'b0; waitq(); sclM = 1'b1; waitq(); ack = ~sdaBus; waitq(); sclM = 1'b0; waitq();
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] b);
    sdaMOe = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      waitq(); sclM = 1'b1; waitq(); b[i] = sdaBus; waitq(); sclM = 1'b0;
    end
    waitq(); sdaMOe = ackIt; waitq(); sclM = 1'b1; waitq(); waitq(); sclM = 1'b0; waitq();
    sdaMOe = 1'b0;
  endtask

  task automatic writeSeq(input logic [7:0] dev, input logic [7:0] addr, input int n,
                          input logic [7:0] base, input bit glitch, output bit allAck);
    bit a;
    startC();
    sendByte(dev, glitch, a); allAck = a;
    sendByte(addr, glitch, a); allAck &= a;
    for (int i = 0; i < n; i++) begin
      sendByte(8'(base + i), glitch, a); allAck &= a;
    end
    stopC();
  endtask

  task automatic readSeq(input logic [7:0] dev, input logic [7:0] addr, input int n);
    bit a;
    logic [7:0] v;
    startC();
    sendByte(dev, 1'b0, a);
    sendByte(addr, 1'b0, a);
    startC();
    sendByte(dev | 8'h01, 1'b0, a);
    for (int i = 0; i < n; i++) begin
      recvByte(i < n - 1, v);
      rdBuf[i] = v;
    end
    stopC();
  endtask

  task automatic pollReady(input logic [7:0] dev, output int tries);
    bit a;
    tries = 0;
    for (int k = 0; k < 40; k++) begin
      startC(); sendByte(dev, 1'b0, a); stopC();
      if (a) break;
      tries++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit a;
    int tries;
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1: bus released, erased content
    checkEq("R1 sda released", int'(sdaBus), 1);
    readSeq(8'hA0, 8'h10, 1);
    checkEq("R1 erased byte", rdBuf[0], 8'hFF);

    // R2: device-select decoding
    startC(); sendByte(8'hA6, 1'b0, a); stopC();
    checkEq("R2 wrong pins nack", int'(a), 0);
    startC(); sendByte(8'hB0, 1'b0, a); stopC();
    checkEq("R2 wrong prefix nack", int'(a), 0);
    startC(); sendByte(8'hA0, 1'b0, a); stopC();
    checkEq("R2 match ack", int'(a), 1);

    // R3 byte write, R5 busy polling, R7 random read
    writeSeq(8'hA0, 8'h21, 1, 8'h5C, 1'b0, a);
    checkEq("R3 write acked", int'(a), 1);
    pollReady(8'hA0, tries);
    checkEq("R5 nack while busy", int'(tries >= 1), 1);
    checkEq("R5 ack after cycle", int'(tries < 40), 1);
    readSeq(8'hA0, 8'h21, 2);
    checkEq("R7 random read", rdBuf[0], 8'h5C);
    checkEq("R3 neighbour kept", rdBuf[1], 8'hFF);

    // R4 page write with in-page wrap: 10 bytes from offset 6
    writeSeq(8'hA0, 8'h46, 10, 8'h30, 1'b0, a);
    pollReady(8'hA0, tries);
    readSeq(8'hA0, 8'h40, 8);
    for (int k = 0; k < 8; k++) checkEq("R4 page wrap", rdBuf[k], 8'h32 + k);

    // R6 write protect
    wp = 1'b1;
    writeSeq(8'hA0, 8'h21, 1, 8'hAA, 1'b0, a);
    wp = 1'b0;
    checkEq("R6 data acked", int'(a), 1);
    pollReady(8'hA0, tries);
    checkEq("R6 no write cycle", tries, 0);
    readSeq(8'hA0, 8'h21, 1);
    checkEq("R6 array kept", rdBuf[0], 8'h5C);

    // R9 STOP in mid-byte
    startC(); sendByte(8'hA0, 1'b0, a); sendByte(8'h60, 1'b0, a); sendByte(8'h11, 1'b0, a);
    sendBits(8'hF0, 4); stopC();
    pollReady(8'hA0, tries);
    checkEq("R9 stop abort no cycle", tries, 0);
    readSeq(8'hA0, 8'h60, 1);
    checkEq("R9 stop abort array", rdBuf[0], 8'hFF);
    // R9 START in mid-byte
    startC(); sendByte(8'hA0, 1'b0, a); sendByte(8'h61, 1'b0, a); sendByte(8'h22, 1'b0, a);
    sendBits(8'h50, 3); startC(); stopC();
    pollReady(8'hA0, tries);
    checkEq("R9 start abort no cycle", tries, 0);
    readSeq(8'hA0, 8'h61, 1);
    checkEq("R9 start abort array", rdBuf[0], 8'hFF);

    // R8 sequential read across the top of the array
    writeSeq(8'hA0, 8'h00, 2, 8'h0A, 1'b0, a);
    pollReady(8'hA0, tries);
    writeSeq(8'hA0, 8'hFE, 2, 8'hE1, 1'b0, a);
    pollReady(8'hA0, tries);
    readSeq(8'hA0, 8'hFE, 4);
    for (int k = 0; k < 4; k++)
      checkEq("R8 sequential wrap", rdBuf[k], (k < 2) ? (8'hE1 + k) : (8'h0A + k - 2));
    checkEq("R8 released after nack", int'(sdaBus), 1);

    // R10 short SCL pulses inside every low phase
    writeSeq(8'hA0, 8'h30, 1, 8'h96, 1'b1, a);
    checkEq("R10 glitched write acked", int'(a), 1);
    pollReady(8'hA0, tries);
    readSeq(8'hA0, 8'h30, 2);
    checkEq("R10 glitched data", rdBuf[0], 8'h96);
    checkEq("R10 no extra byte", rdBuf[1], 8'hFF);

    // R11 128-byte variant ignores the address MSB
    writeSeq(8'hAA, 8'h85, 1, 8'h77, 1'b0, a);
    checkEq("R11 small acked", int'(a), 1);
    pollReady(8'hAA, tries);
    readSeq(8'hAA, 8'h05, 1);
    checkEq("R11 msb ignored", rdBuf[0], 8'h77);
    readSeq(8'hA0, 8'h85, 1);
    checkEq("R2 other target untouched", rdBuf[0], 8'hFF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule